// File: doc/BRIEF.md
# Event-State-Buffer Access Decoder

This block sits between a memory-mapped bus port and a per-source interrupt state array. Every source owns a slice of an address window. A bus load or store into that slice is turned into one command for the state array: trigger, end-of-interrupt (EOI), read of the two-bit PQ state, or an overwrite of PQ. The block returns the load data and flags accesses that it cannot honour. It does not hold any PQ state and does not route notifications.

The slice size and arrangement come from `cfg_layout`. A single-page layout gives each source one 4 KiB or 64 KiB page. A two-page layout gives each source a pair of pages. The lower page of the pair only accepts triggers. The upper page carries the management operations. Inside a management page, the operation is chosen by bits [11:8] of the page offset. The value stored on the bus is never used. Loads return their result in the low bits of the 64-bit word, with the upper bits zero, except where a requirement below says all ones. The array answers each load command on `cmd_rsp_valid`. The decoder presents the load result one cycle after that answer and accepts no new access while it waits.

Top module: `esb_mmio_decoder`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `rsp_valid` and `err_valid` are 0.
- R2: `cfg_layout` selects the page shift. Code 0 is 64 KiB two-page (shift 17), 1 is 64 KiB single-page (shift 16), 2 is 4 KiB two-page (shift 13) and 3 is 4 KiB single-page (shift 12). `cmd_src` is `req_addr >> shift`.
- R3: In a two-page layout, an access with address bit (shift-1) = 0 hits the trigger page. A store there issues a trigger whatever its offset. A load there issues no command, pulses `err_valid` and returns all ones.
- R4: A load at page offset 0x000-0x7FF issues an EOI. Its result is bit 0 of the array answer, with all other bits zero.
- R5: A load at offset 0x800-0xBFF issues a PQ read and returns the 2-bit array answer unchanged.
- R6: A load or store at offset 0xC00-0xFFF issues a PQ overwrite with `cmd_pq` = offset bits [9:8]. A load there returns the array answer, which is the previous PQ.
- R7: A store at offset 0x000-0x3FF issues a trigger, and no store ever produces `rsp_valid`.
- R8: A store at offset 0x400-0x7FF issues an EOI when `cfg_store_eoi` is 1. When `cfg_store_eoi` is 0 it issues nothing and pulses `err_valid`.
- R9: A store at offset 0x800-0xBFF issues nothing and pulses `err_valid`. `err_valid` and `cmd_valid` are never high together.
- R10: An access with `req_bytes` other than 8 issues nothing and pulses `err_valid`. If it is a load, it returns all ones.
- R11: An access is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The command, or the error pulse, appears in the following cycle. A load that issued a command holds `req_ready` low until `cmd_rsp_valid`, and its result appears in the cycle after that. A load that issued no command answers in the cycle after acceptance.
- R12: In the cycle where a load result is presented, `req_ready` is already 1, so the next access is accepted there.
- Op codes on `cmd_op`: 0 trigger, 1 EOI, 2 PQ read, 3 PQ overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_layout | input | 2 | Page layout code (R2) |
| cfg_store_eoi | input | 1 | Enables EOI by store |
| req_valid | input | 1 | Bus access present |
| req_ready | output | 1 | Decoder can accept an access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_bytes | input | 4 | Access size in bytes |
| rsp_valid | output | 1 | Load result present |
| rsp_data | output | 64 | Load result |
| err_valid | output | 1 | Invalid-access pulse |
| cmd_valid | output | 1 | Command to the state array |
| cmd_op | output | 2 | Command code |
| cmd_src | output | ADDR_W-12 | Source number |
| cmd_pq | output | 2 | PQ value for an overwrite |
| cmd_rsp_valid | input | 1 | Array answer to a load command |
| cmd_rsp_data | input | 2 | Array answer value |

## Verification
Two events can share a cycle: a load result leaving on `rsp_data`, and the acceptance of the next access. The bench has the array answer in the same cycle as the load command. It then drives a store at the instant the result appears, and checks both the result value and the store's trigger command in the cycle after. A separate case makes the array answer three cycles late. It checks that a request offered during the wait is neither accepted nor decoded.

// File: rtl/esb_pkg.sv
// Shared types and constants for the event-state-buffer access decoder.
// Assumes a 4 KiB page offset and 8-byte bus accesses.
package esb_pkg;

    typedef enum logic [1:0] {
        OP_TRIGGER = 2'd0,
        OP_EOI     = 2'd1,
        OP_GET     = 2'd2,
        OP_SET     = 2'd3
    } esb_op_e;

    localparam int PAGE_OFF_W   = 12;
    localparam int ACCESS_BYTES = 8;
    localparam int RSP_W        = 64;
    localparam int LAYOUTS      = 4;

    // Decoded form of one access
    typedef struct packed {
        logic    issue;     // a command goes to the array
        esb_op_e op;
        logic [1:0] pq;
        logic    err;       // invalid access
        logic    load_cmd;  // load waiting on the array answer
        logic    load_imm;  // load answered at once with all ones
    } esb_dec_t;

    // Page shift for a layout code: bit1 picks 4 KiB, bit0 picks single-page
    function automatic int layout_shift(input int code);
        return (((code & 2) != 0) ? 13 : 17) - (code & 1);
    endfunction

endpackage

// File: rtl/esb_addr_split.sv
// Splits a window address into a source number, the offset bits that select
// the operation, and a trigger-page flag, for every layout in parallel.
// The result is then picked by the layout code. Assumes ADDR_W >= 17.
module esb_addr_split
    import esb_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int SRC_W = ADDR_W - PAGE_OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        layout,
    output logic [SRC_W-1:0]  src,
    output logic [3:0]        op_bits,
    output logic              trig_page
);

    logic [SRC_W-1:0] cand_src  [LAYOUTS];
    logic             cand_trig [LAYOUTS];
    logic             unused_low;

    // One candidate per layout
    for (genvar i = 0; i < LAYOUTS; i++) begin : g_layout
        localparam int SH = layout_shift(i);
        assign cand_src[i]  = SRC_W'(addr >> SH);
        assign cand_trig[i] = ((i % 2) == 0) ? !addr[SH-1] : 1'b0;
    end

    // Pick the candidate for the active layout
    assign src       = cand_src[layout];
    assign trig_page = cand_trig[layout];
    assign op_bits   = addr[11:8];
    assign unused_low = ^addr[7:0];

endmodule

// File: rtl/esb_op_decode.sv
// Maps access direction, size, page kind and offset bits [11:8] to a command,
// an error, or an immediate all-ones load. Purely combinational.
module esb_op_decode
    import esb_pkg::*;
(
    input  logic       wr,
    input  logic [3:0] nbytes,
    input  logic [3:0] op_bits,
    input  logic       trig_page,
    input  logic       store_eoi_en,
    output esb_dec_t   dec
);

    // Decode one access
    always_comb begin
        dec    = '0;
        dec.op = OP_TRIGGER;
        dec.pq = op_bits[1:0];
        if (nbytes != 4'(ACCESS_BYTES)) begin
            dec.err      = 1'b1;
            dec.load_imm = !wr;
        end else if (trig_page) begin
            dec.issue    = wr;
            dec.err      = !wr;
            dec.load_imm = !wr;
        end else if (wr) begin
            unique case (op_bits[3:2])
                2'b00: dec.issue = 1'b1;
                2'b01: begin
                    dec.issue = store_eoi_en;
                    dec.err   = !store_eoi_en;
                    dec.op    = OP_EOI;
                end
                2'b10: dec.err = 1'b1;
                default: begin
                    dec.issue = 1'b1;
                    dec.op    = OP_SET;
                end
            endcase
        end else begin
            dec.issue    = 1'b1;
            dec.load_cmd = 1'b1;
            if (!op_bits[3])      dec.op = OP_EOI;
            else if (!op_bits[2]) dec.op = OP_GET;
            else                  dec.op = OP_SET;
        end
    end

endmodule

// File: rtl/esb_load_track.sv
// Tracks the one load that may wait on the array. Forms the load result a
// cycle after the array answer, or a cycle after acceptance for loads that
// need no command. Assumes the array answers only after the command.
module esb_load_track
    import esb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             start_eoi,
    input  logic             start_imm,
    input  logic             arr_valid,
    input  logic [1:0]       arr_data,
    output logic             busy,
    output logic             rsp_valid,
    output logic [RSP_W-1:0] rsp_data
);

    logic wait_eoi;

    // Wait state and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            wait_eoi  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (start_imm) begin
                rsp_valid <= 1'b1;
                rsp_data  <= '1;
            end
            if (start_cmd) begin
                busy     <= 1'b1;
                wait_eoi <= start_eoi;
            end else if (busy && arr_valid) begin
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_data  <= wait_eoi ? {{(RSP_W-1){1'b0}}, arr_data[0]}
                                      : {{(RSP_W-2){1'b0}}, arr_data};
            end
        end
    end

endmodule

// File: rtl/esb_mmio_decoder.sv
// Top of the access decoder: accepts one bus access when idle, decodes it,
// and registers the array command and the error pulse. Store data is not
// needed and is not taken in.
module esb_mmio_decoder
    import esb_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int SRC_W = ADDR_W - PAGE_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_layout,
    input  logic              cfg_store_eoi,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_bytes,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_data,
    output logic              err_valid,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [SRC_W-1:0]  cmd_src,
    output logic [1:0]        cmd_pq,
    input  logic              cmd_rsp_valid,
    input  logic [1:0]        cmd_rsp_data
);

    logic [SRC_W-1:0] src;
    logic [3:0]       op_bits;
    logic             trig_page;
    esb_dec_t         dec;
    logic             busy;
    logic             accept;

    esb_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr      (req_addr),
        .layout    (cfg_layout),
        .src       (src),
        .op_bits   (op_bits),
        .trig_page (trig_page)
    );

    esb_op_decode u_dec (
        .wr           (req_write),
        .nbytes       (req_bytes),
        .op_bits      (op_bits),
        .trig_page    (trig_page),
        .store_eoi_en (cfg_store_eoi),
        .dec          (dec)
    );

    esb_load_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (accept && dec.load_cmd),
        .start_eoi (dec.op == OP_EOI),
        .start_imm (accept && dec.load_imm),
        .arr_valid (cmd_rsp_valid),
        .arr_data  (cmd_rsp_data),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    // Command and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            err_valid <= 1'b0;
            cmd_op    <= 2'd0;
            cmd_src   <= '0;
            cmd_pq    <= 2'd0;
        end else begin
            cmd_valid <= accept && dec.issue;
            err_valid <= accept && dec.err;
            if (accept && dec.issue) begin
                cmd_op  <= dec.op;
                cmd_src <= src;
                cmd_pq  <= dec.pq;
            end
        end
    end

endmodule

// File: rtl/esb_mmio_decoder_chk.sv
// Protocol checks on the decoder ports, bound to every decoder instance.
module esb_mmio_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [3:0]  req_bytes,
    input logic        rsp_valid,
    input logic        err_valid,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        cmd_rsp_valid
);

    // R9: an error pulse never carries a command
    p_cmd_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && err_valid));

    // R5: a PQ read only follows a load
    p_get_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> $past(!req_write));

    // R7: a store never yields a load result
    p_store_no_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rsp_valid);

    // R11: the array answer to a waiting load gives a result next cycle
    p_rsp_after_arr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rsp_valid && !req_ready) |=> rsp_valid);

    // R11: nothing is decoded while the decoder is busy
    p_busy_no_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !cmd_valid);

    // R10: a wrong size gives an error and no command
    p_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bytes != 4'd8) |=> (err_valid && !cmd_valid));

endmodule

bind esb_mmio_decoder esb_mmio_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/esb_mmio_decoder_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module esb_mmio_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int SRC_W      = ADDR_W - 12;
    localparam int NVEC       = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_layout = 2'd0;
    logic              cfg_store_eoi = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_bytes = 4'd8;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic              err_valid;
    logic              cmd_valid;
    logic [1:0]        cmd_op;
    logic [SRC_W-1:0]  cmd_src;
    logic [1:0]        cmd_pq;
    logic              cmd_rsp_valid = 1'b0;
    logic [1:0]        cmd_rsp_data = 2'd0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    esb_mmio_decoder #(.ADDR_W(ADDR_W)) u_dut (.*);

    typedef struct packed {
        logic       wr;
        logic [3:0] nb;
        logic [1:0] lay;
        logic       eoien;
        logic [7:0] src;
        logic       odd;
        logic [11:0] off;
        logic [1:0] arr;
        logic       ecmd;
        logic [1:0] eop;
        logic [1:0] epq;
        logic       eerr;
        logic       eones;
        logic [1:0] edat;
        logic [3:0] req;
    } vec_t;

    // wr nb lay eoien src odd off arr | ecmd eop epq eerr eones edat req
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,4'd8,2'd0,1'b0,8'd5,  1'b1,12'hE00,2'd1, 1'b1,2'd3,2'd2,1'b0,1'b0,2'd1,4'd6},  // R6 load
        '{1'b0,4'd8,2'd0,1'b0,8'd3,  1'b1,12'h123,2'd3, 1'b1,2'd1,2'd0,1'b0,1'b0,2'd1,4'd4},  // R4 mask
        '{1'b0,4'd8,2'd0,1'b0,8'd3,  1'b1,12'h456,2'd2, 1'b1,2'd1,2'd0,1'b0,1'b0,2'd0,4'd4},  // R4
        '{1'b0,4'd8,2'd0,1'b0,8'd7,  1'b1,12'h9A0,2'd2, 1'b1,2'd2,2'd0,1'b0,1'b0,2'd2,4'd5},  // R5
        '{1'b0,4'd8,2'd0,1'b0,8'd7,  1'b0,12'h800,2'd0, 1'b0,2'd0,2'd0,1'b1,1'b1,2'd0,4'd3},  // R3 load
        '{1'b1,4'd8,2'd0,1'b0,8'd2,  1'b0,12'hC00,2'd0, 1'b1,2'd0,2'd0,1'b0,1'b0,2'd0,4'd3},  // R3 store
        '{1'b1,4'd8,2'd0,1'b0,8'd2,  1'b1,12'h010,2'd0, 1'b1,2'd0,2'd0,1'b0,1'b0,2'd0,4'd7},  // R7
        '{1'b1,4'd8,2'd0,1'b0,8'd2,  1'b1,12'h500,2'd0, 1'b0,2'd0,2'd0,1'b1,1'b0,2'd0,4'd8},  // R8 off
        '{1'b1,4'd8,2'd0,1'b1,8'd2,  1'b1,12'h500,2'd0, 1'b1,2'd1,2'd0,1'b0,1'b0,2'd0,4'd8},  // R8 on
        '{1'b1,4'd8,2'd0,1'b0,8'd2,  1'b1,12'hA00,2'd0, 1'b0,2'd0,2'd0,1'b1,1'b0,2'd0,4'd9},  // R9
        '{1'b1,4'd8,2'd0,1'b0,8'd9,  1'b1,12'hD40,2'd0, 1'b1,2'd3,2'd1,1'b0,1'b0,2'd0,4'd6},  // R6 store
        '{1'b0,4'd8,2'd1,1'b0,8'd4,  1'b0,12'h300,2'd1, 1'b1,2'd1,2'd0,1'b0,1'b0,2'd1,4'd2},  // R2 64K one
        '{1'b0,4'd8,2'd3,1'b0,8'd200,1'b0,12'hF00,2'd0, 1'b1,2'd3,2'd3,1'b0,1'b0,2'd0,4'd2},  // R2 4K one
        '{1'b0,4'd8,2'd2,1'b0,8'd6,  1'b0,12'h400,2'd0, 1'b0,2'd0,2'd0,1'b1,1'b1,2'd0,4'd3},  // R3 4K two
        '{1'b1,4'd8,2'd2,1'b1,8'd6,  1'b1,12'h7FF,2'd0, 1'b1,2'd1,2'd0,1'b0,1'b0,2'd0,4'd8},  // R8 4K two
        '{1'b0,4'd4,2'd0,1'b0,8'd1,  1'b1,12'h800,2'd0, 1'b0,2'd0,2'd0,1'b1,1'b1,2'd0,4'd10}, // R10 load
        '{1'b1,4'd4,2'd0,1'b0,8'd1,  1'b0,12'h000,2'd0, 1'b0,2'd0,2'd0,1'b1,1'b0,2'd0,4'd10}, // R10 store
        '{1'b1,4'd8,2'd3,1'b0,8'd255,1'b0,12'hCFF,2'd0, 1'b1,2'd3,2'd0,1'b0,1'b0,2'd0,4'd6}   // R6 pq 00
    };

    function automatic string req_name(input int n);
        case (n)
            2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";
            8: return "R8";   9: return "R9";   10: return "R10";
            default: return "R?";
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [1:0] lay, input logic [7:0] src,
                                                  input logic odd, input logic [11:0] off);
        int sh;
        sh = (lay[1] ? 13 : 17) - int'(lay[0]);
        return (ADDR_W'(src) << sh) | (lay[0] ? '0 : (ADDR_W'(odd) << (sh - 1))) | ADDR_W'(off);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(!cmd_valid && !rsp_valid && !err_valid, "R1", "outputs idle",
            {61'd0, cmd_valid, rsp_valid, err_valid}, 64'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            automatic vec_t v = VECS[i];
            automatic string t = req_name(int'(v.req));
            cfg_layout    = v.lay;
            cfg_store_eoi = v.eoien;
            req_write     = v.wr;
            req_bytes     = v.nb;
            req_addr      = mk_addr(v.lay, v.src, v.odd, v.off);
            req_valid     = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(cmd_valid == v.ecmd, t, "cmd_valid", 64'(cmd_valid), 64'(v.ecmd));
            chk(err_valid == v.eerr, t, "err_valid", 64'(err_valid), 64'(v.eerr));
            if (v.ecmd) begin
                chk(cmd_op == v.eop, t, "cmd_op", 64'(cmd_op), 64'(v.eop));
                chk(cmd_src == SRC_W'(v.src), t, "cmd_src", 64'(cmd_src), 64'(v.src));
                if (v.eop == 2'd3)
                    chk(cmd_pq == v.epq, t, "cmd_pq", 64'(cmd_pq), 64'(v.epq));
            end
            if (v.wr) begin
                chk(!rsp_valid, t, "no store response", 64'(rsp_valid), 64'd0);
            end else if (v.ecmd) begin
                // R11: result waits for the array answer
                chk(!rsp_valid && !req_ready, t, "waiting load",
                    {62'd0, rsp_valid, req_ready}, 64'd0);
                cmd_rsp_valid = 1'b1;
                cmd_rsp_data  = v.arr;
                @(negedge clk);
                cmd_rsp_valid = 1'b0;
                chk(rsp_valid, t, "rsp_valid", 64'(rsp_valid), 64'd1);
                chk(rsp_data == {62'd0, v.edat}, t, "rsp_data", rsp_data, {62'd0, v.edat});
            end else begin
                chk(rsp_valid, t, "rsp_valid", 64'(rsp_valid), 64'd1);
                chk(rsp_data == '1, t, "rsp_data ones", rsp_data, '1);
            end
            @(negedge clk);
        end

        // R11: late array answer, a request offered while busy is not taken
        cfg_layout = 2'd0; cfg_store_eoi = 1'b0;
        req_write = 1'b0; req_bytes = 4'd8;
        req_addr = mk_addr(2'd0, 8'd1, 1'b1, 12'h800);
        req_valid = 1'b1;
        @(negedge clk);
        chk(cmd_valid && cmd_op == 2'd2, "R11", "late load cmd", {62'd0, cmd_op}, 64'd2);
        req_write = 1'b1;
        req_addr  = mk_addr(2'd0, 8'd9, 1'b1, 12'h000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!req_ready && !cmd_valid && !rsp_valid, "R11", "busy idle",
                {61'd0, req_ready, cmd_valid, rsp_valid}, 64'd0);
        end
        req_valid = 1'b0;
        cmd_rsp_valid = 1'b1; cmd_rsp_data = 2'd2;
        @(negedge clk);
        cmd_rsp_valid = 1'b0;
        chk(rsp_valid && rsp_data == 64'd2, "R11", "late result", rsp_data, 64'd2);
        chk(!cmd_valid, "R11", "busy store dropped", 64'(cmd_valid), 64'd0);
        @(negedge clk);

        // R12: next access accepted in the result cycle
        req_write = 1'b0;
        req_addr  = mk_addr(2'd0, 8'd3, 1'b1, 12'hF00);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cmd_rsp_valid = 1'b1; cmd_rsp_data = 2'd1;
        @(negedge clk);
        cmd_rsp_valid = 1'b0;
        chk(rsp_valid && rsp_data == 64'd1, "R12", "result", rsp_data, 64'd1);
        chk(req_ready, "R12", "ready with result", 64'(req_ready), 64'd1);
        req_write = 1'b1;
        req_addr  = mk_addr(2'd0, 8'd4, 1'b1, 12'h000);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_valid && cmd_op == 2'd0 && cmd_src == SRC_W'(4), "R12", "overlapped trigger",
            64'(cmd_src), 64'd4);
        chk(!rsp_valid, "R12", "single result", 64'(rsp_valid), 64'd0);
        @(negedge clk);

        finish_run();
    end

endmodule